// File: doc/BRIEF.md
# Prioritised Interrupt Request Latch

This block sits between the interrupt sources of a small 8-bit controller and its CPU sequencer. It watches two active-low external interrupt pins and a timer request level. Each pin goes through a synchroniser, and a falling edge on it is captured in a request latch. At the end of every instruction, the block picks one pending request and offers it to the sequencer together with the address of its vector word. It holds that offer until the sequencer acknowledges it.

The primary pin has its own vector and its own latch, which the acknowledge clears. The timer and the second pin share one vector. The request flag of the second pin sits in a small control register next to its enable-inhibit flag, so a handler can tell the two shared sources apart. Software can only clear that flag. While the CPU's global mask bit is set, nothing is offered. Requests stay latched and are offered at the first instruction boundary after the mask drops. The block also drives the constant vector address that the sequencer uses for the software-interrupt instruction.

Top module: `intp_ctrl`

## Requirements
- R1: After reset, no request is offered (`irq_valid` low) and the control register reads 8'h40: request flag (bit 7) clear and inhibit flag (bit 6) set.
- R2: A falling edge on `ext_irq_n` latches the primary request. A pin that stays low, or a rising edge, latches nothing further. The primary vector address is VEC_BASE+2 (12'hFFA by default).
- R3: A falling edge on `aux_irq_n` sets control-register bit 7, whatever the value of bit 6.
- R4: While control-register bit 6 is 1, a set bit 7 does not cause an offer. Once bit 6 is written to 0, the pending bit 7 is offered at the next boundary.
- R5: The timer request (`tmr_req` high) and an uninhibited second-pin request both offer the shared vector address VEC_BASE (12'hFF8 by default).
- R6: A register write with bit 7 = 0 clears the request flag, and a write with bit 7 = 1 leaves it unchanged. An acknowledge does not clear it. Bit 6 takes the written value.
- R7: While `cpu_imask` is high, no request is offered. Latched requests are kept and are offered at the first boundary after `cpu_imask` goes low.
- R8: Requests are evaluated only in a cycle with `insn_done` high. `irq_valid` rises on the clock edge that ends that cycle.
- R9: When the primary request and a shared request are pending together, the primary vector is offered first.
- R10: Once raised, `irq_valid` and `irq_vec` hold until `ack`. `ack` drops `irq_valid` on the next edge. Acknowledging the primary vector clears the primary latch.
- R11: `swi_vec` always reads VEC_BASE+4 (12'hFFC by default).
- R12: Control-register bits 5 to 0 always read as 0.
- R13: A low pulse of one clock cycle on either pin is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_irq_n | input | 1 | Primary interrupt pin, falling-edge active |
| aux_irq_n | input | 1 | Second interrupt pin, falling-edge active |
| tmr_req | input | 1 | Timer request level |
| cpu_imask | input | 1 | CPU global interrupt mask |
| insn_done | input | 1 | Instruction-boundary strobe |
| ack | input | 1 | Sequencer has taken the offered vector |
| reg_wr | input | 1 | Control-register write strobe |
| reg_wdata | input | 8 | Control-register write data |
| reg_rdata | output | 8 | Control-register read data |
| irq_valid | output | 1 | A request is being offered |
| irq_vec | output | ADDR_W | Vector address of the offered request |
| swi_vec | output | ADDR_W | Software-interrupt vector address |

## Verification
The bench builds the block with its defaults: a 12-bit address, shared vector base 12'hFF8 and a two-stage synchroniser. This makes the three vector addresses concrete values that the bench can compare directly. With two stages, a pin edge reaches the latch within three clock edges, so the bench can pulse a pin, wait a few cycles and then strobe a boundary. That timing covers single-cycle pulses and the masked-and-held cases within a short run.

// File: rtl/intp_pkg.sv
package intp_pkg;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_EXT    = 2'd1,
    SRC_SHARED = 2'd2
  } src_e;

  // word distance between consecutive vector slots
  localparam int unsigned VEC_STEP = 2;

  // primary pin outranks the shared timer / second-pin slot
  function automatic src_e pick_src(input logic ext_pend, input logic shr_pend);
    if (ext_pend)      return SRC_EXT;
    else if (shr_pend) return SRC_SHARED;
    else               return SRC_NONE;
  endfunction

  // slot index of each source above the shared base
  function automatic int unsigned slot_of(input src_e s);
    case (s)
      SRC_EXT: return 1;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/intp_edge_cap.sv
module intp_edge_cap #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall
);
  logic [STAGES-1:0] sr;
  logic              prev;
  logic              synced;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '1;
        else        sr <= pin_n;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '1;
        else        sr <= {sr[STAGES-2:0], pin_n};
      end
    end
  endgenerate

  assign synced = sr[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= synced;
  end

  assign fall = prev & ~synced;
endmodule

// File: rtl/intp_aux_reg.sv
module intp_aux_reg #(
  parameter int unsigned REQ_BIT  = 7,
  parameter int unsigned MSK_BIT  = 6,
  parameter logic        MASK_RST = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_req,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       req,
  output logic       inhibit,
  output logic [7:0] rdata
);
  logic clr_req;
  assign clr_req = wr & ~wdata[REQ_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       req <= 1'b0;
    else if (set_req) req <= 1'b1;
    else if (clr_req) req <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  inhibit <= MASK_RST;
    else if (wr) inhibit <= wdata[MSK_BIT];
  end

  always_comb begin
    rdata          = '0;
    rdata[REQ_BIT] = req;
    rdata[MSK_BIT] = inhibit;
  end
endmodule

// File: rtl/intp_arb.sv
module intp_arb
  import intp_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned VEC_BASE = 'hFF8
) (
  input  logic              ext_pend,
  input  logic              shr_pend,
  output src_e              src,
  output logic [ADDR_W-1:0] vec
);
  always_comb begin
    src = pick_src(ext_pend, shr_pend);
    vec = ADDR_W'(VEC_BASE + VEC_STEP * slot_of(src));
  end
endmodule

// File: rtl/intp_ctrl.sv
module intp_ctrl
  import intp_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned VEC_BASE    = 'hFF8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_irq_n,
  input  logic              aux_irq_n,
  input  logic              tmr_req,
  input  logic              cpu_imask,
  input  logic              insn_done,
  input  logic              ack,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq_valid,
  output logic [ADDR_W-1:0] irq_vec,
  output logic [ADDR_W-1:0] swi_vec
);
  localparam int unsigned NPINS = 2;
  localparam int unsigned PIN_EXT = 0;
  localparam int unsigned PIN_AUX = 1;

  logic [NPINS-1:0] pins_n;
  logic [NPINS-1:0] falls;
  assign pins_n = {aux_irq_n, ext_irq_n};

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
      intp_edge_cap #(.STAGES(SYNC_STAGES)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (pins_n[i]),
        .fall  (falls[i])
      );
    end
  endgenerate

  // named internal events
  logic ext_fall, aux_fall;
  logic ext_lat, aux_req, aux_inhibit;
  logic shared_pend, any_pend, take, ext_acked;
  src_e sel_src, cur_src;
  logic [ADDR_W-1:0] sel_vec;

  assign ext_fall = falls[PIN_EXT];
  assign aux_fall = falls[PIN_AUX];

  intp_aux_reg #(.REQ_BIT(7), .MSK_BIT(6), .MASK_RST(1'b1)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (aux_fall),
    .wr      (reg_wr),
    .wdata   (reg_wdata),
    .req     (aux_req),
    .inhibit (aux_inhibit),
    .rdata   (reg_rdata)
  );

  assign shared_pend = tmr_req | (aux_req & ~aux_inhibit);
  assign any_pend    = ext_lat | shared_pend;
  assign take        = insn_done & ~irq_valid & ~cpu_imask & any_pend;
  assign ext_acked   = ack & irq_valid & (cur_src == SRC_EXT);

  intp_arb #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_arb (
    .ext_pend (ext_lat),
    .shr_pend (shared_pend),
    .src      (sel_src),
    .vec      (sel_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ext_lat <= 1'b0;
    else if (ext_fall)  ext_lat <= 1'b1;
    else if (ext_acked) ext_lat <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_vec   <= '0;
      cur_src   <= SRC_NONE;
    end else if (irq_valid && ack) begin
      irq_valid <= 1'b0;
      cur_src   <= SRC_NONE;
    end else if (take) begin
      irq_valid <= 1'b1;
      irq_vec   <= sel_vec;
      cur_src   <= sel_src;
    end
  end

  assign swi_vec = ADDR_W'(VEC_BASE + 2 * VEC_STEP);
endmodule

// File: rtl/intp_ctrl_chk.sv
module intp_ctrl_chk #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned VEC_BASE = 'hFF8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              insn_done,
  input logic              cpu_imask,
  input logic              ack,
  input logic              irq_valid,
  input logic [ADDR_W-1:0] irq_vec,
  input logic              ext_lat,
  input logic              shared_pend,
  input logic              reg_wr,
  input logic              aux_fall,
  input logic              aux_req
);
  localparam logic [ADDR_W-1:0] SHR_VEC = ADDR_W'(VEC_BASE);
  localparam logic [ADDR_W-1:0] EXT_VEC = ADDR_W'(VEC_BASE + 2);

  p_boundary_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_valid && !insn_done) |=> !irq_valid);

  p_imask_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_valid && cpu_imask) |=> !irq_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !ack) |=> (irq_valid && $stable(irq_vec)));

  p_ack_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && ack) |=> !irq_valid);

  p_ext_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && !irq_valid && !cpu_imask && ext_lat) |=> (irq_valid && irq_vec == EXT_VEC));

  p_shared_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && !irq_valid && !cpu_imask && !ext_lat && shared_pend) |=> (irq_valid && irq_vec == SHR_VEC));

  p_one_no_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !aux_fall && !aux_req) |=> !aux_req);

  p_pin_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    aux_fall |=> aux_req);
endmodule

bind intp_ctrl intp_ctrl_chk #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .insn_done   (insn_done),
  .cpu_imask   (cpu_imask),
  .ack         (ack),
  .irq_valid   (irq_valid),
  .irq_vec     (irq_vec),
  .ext_lat     (ext_lat),
  .shared_pend (shared_pend),
  .reg_wr      (reg_wr),
  .aux_fall    (aux_fall),
  .aux_req     (aux_req)
);

// File: tb/intp_ctrl_tb.sv
`timescale 1ns/1ps
module intp_ctrl_tb;
  localparam int unsigned ADDR_W = 12;
  localparam logic [11:0] V_SHR = 12'hFF8;
  localparam logic [11:0] V_EXT = 12'hFFA;
  localparam logic [11:0] V_SWI = 12'hFFC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_irq_n = 1'b1, aux_irq_n = 1'b1, tmr_req = 1'b0, cpu_imask = 1'b0;
  logic insn_done = 1'b0, ack = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq_valid;
  logic [ADDR_W-1:0] irq_vec, swi_vec;

  always #2.5 clk = ~clk;

  intp_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .aux_irq_n(aux_irq_n),
    .tmr_req(tmr_req), .cpu_imask(cpu_imask), .insn_done(insn_done), .ack(ack),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .swi_vec(swi_vec)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic boundary();
    insn_done = 1'b1; step(); insn_done = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d; step(); reg_wr = 1'b0;
  endtask

  task automatic pulse(input bit e, input bit a);
    if (e) ext_irq_n = 1'b0;
    if (a) aux_irq_n = 1'b0;
    step();
    ext_irq_n = 1'b1; aux_irq_n = 1'b1;
    step(4);
  endtask

  task automatic drain();
    cpu_imask = 1'b0; tmr_req = 1'b0;
    wr_reg(8'h40);
    for (int k = 0; k < 3; k++) begin
      boundary();
      if (irq_valid) do_ack();
    end
  endtask

  typedef struct packed {
    logic        imask;
    logic        tmr;
    logic        aux_open;
    logic        ext_edge;
    logic        aux_edge;
    logic        exp_valid;
    logic [11:0] exp_vec;
  } row_t;

  localparam row_t TBL [8] = '{
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 12'hFFA},  // R2 primary
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 12'hFF8},  // R5 timer
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 12'hFF8},  // R5 second pin open
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'h000},  // R4 second pin inhibited
    '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 12'hFFA},  // R9 primary over timer
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 12'h000},  // R7 cpu mask
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 12'hFFA},  // R9 primary over second pin
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'h000}   // R8 nothing pending
  };

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    // R1 reset state
    check("R1 valid", irq_valid, 0);
    check("R1 reg", reg_rdata, 8'h40);
    // R11
    check("R11 swi", swi_vec, V_SWI);

    foreach (TBL[i]) begin
      cpu_imask = TBL[i].imask;
      tmr_req   = TBL[i].tmr;
      wr_reg(TBL[i].aux_open ? 8'h00 : 8'h40);
      pulse(TBL[i].ext_edge, TBL[i].aux_edge);
      boundary();
      check($sformatf("R9/R5 row%0d valid", i), irq_valid, TBL[i].exp_valid);
      if (TBL[i].exp_valid) begin
        check($sformatf("R9/R5 row%0d vec", i), irq_vec, TBL[i].exp_vec);
        do_ack();
      end
      drain();
    end

    // R3 / R6 / R12 register behaviour
    pulse(0, 1);
    check("R3 set while inhibited", reg_rdata, 8'hC0);
    wr_reg(8'hC0);
    check("R6 write one no effect", reg_rdata, 8'hC0);
    wr_reg(8'h80);
    check("R6 inhibit written", reg_rdata, 8'h80);
    wr_reg(8'h3F);
    check("R12 low bits zero", reg_rdata, 8'h00);

    // R4 opening the inhibit releases a held request
    wr_reg(8'h40);
    pulse(0, 1);
    boundary();
    check("R4 inhibited", irq_valid, 0);
    wr_reg(8'h80);
    boundary();
    check("R4 released", irq_valid, 1);
    check("R4 vec", irq_vec, V_SHR);
    do_ack();
    // R6 ack leaves request flag
    check("R6 ack keeps flag", reg_rdata[7], 1);
    boundary();
    check("R6 re-offered", irq_valid, 1);
    do_ack();
    wr_reg(8'h00);
    boundary();
    check("R6 cleared by write", irq_valid, 0);
    drain();

    // R7 held under mask then offered
    cpu_imask = 1'b1;
    pulse(1, 0);
    boundary();
    check("R7 masked", irq_valid, 0);
    cpu_imask = 1'b0;
    boundary();
    check("R7 after unmask", irq_valid, 1);
    check("R7 vec", irq_vec, V_EXT);
    // R10 hold until ack
    step(3);
    check("R10 hold", irq_valid, 1);
    check("R10 vec stable", irq_vec, V_EXT);
    do_ack();
    check("R10 ack drops", irq_valid, 0);
    boundary();
    check("R10 latch cleared", irq_valid, 0);

    // R8 no offer without boundary
    pulse(1, 0);
    step(5);
    check("R8 no boundary", irq_valid, 0);
    boundary();
    check("R8 boundary", irq_valid, 1);
    do_ack();

    // R2 steady low and rising edge latch nothing
    ext_irq_n = 1'b0;
    step(5);
    boundary();
    check("R2 first fall", irq_valid, 1);
    do_ack();
    step(5);
    boundary();
    check("R2 steady low", irq_valid, 0);
    ext_irq_n = 1'b1;
    step(5);
    boundary();
    check("R2 rising edge", irq_valid, 0);

    // R13 single-cycle pulse on each pin
    ext_irq_n = 1'b0; step(); ext_irq_n = 1'b1; step(4);
    boundary();
    check("R13 primary pulse", irq_vec, V_EXT);
    do_ack();
    aux_irq_n = 1'b0; step(); aux_irq_n = 1'b1; step(4);
    check("R13 second pin pulse", reg_rdata[7], 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule